// File: doc/BRIEF.md
# Multi-Channel PWM With Shared Prescaler

This block drives up to four pulse-width-modulated outputs from one common timebase. A divider, programmed with an 8-bit prescale value, produces a local tick. An 8-bit counter steps on every local tick, so every channel repeats with the same fixed period of 256 local ticks. Each channel compares this shared counter against its own 8-bit duty value and holds its pin high while the counter has not passed that value. The shortest pulse is one local tick and the longest fills the whole period.

Software reaches the block through a simple 32-bit register port that is word addressed. Duty values are held in a shadow stage and reach the comparators only at a period boundary, so a pulse already in flight is never cut short or stretched. A single run bit starts and stops all channels together. The prescale value is split into two nibbles at separate positions in the control word. A stored interrupt-enable bit is kept for software, but no interrupt logic is attached to it.

Top module: `pwmx_core`

## Requirements
- R1: After reset every register reads 0 and every PWM output is low.
- R2: Registers are selected by byte address bits above bit 1. The duty of channel n is at offset 4*n in bits 7:0. Control is at offset 0x50: prescale bits 3:0 sit in bits 3:0, prescale bits 7:4 sit in bits 14:11, and the run bit is bit 9. Interrupt enable is bit 0 at offset 0x54. All other bits read 0. Read data appears on the clock edge after the read strobe.
- R3: Duty slots for channel indices at or above the configured channel count, and any unmapped offset, read 0. Writes to them change no register and no output.
- R4: While the run bit is 0, all outputs are low and the divider and counter are held at 0.
- R5: With prescale value p, every output repeats with a period of 256*(p+1) input clock cycles. Each counter step lasts p+1 cycles.
- R6: A duty value d gives a high time of (d+1)*(p+1) cycles per period. d=0 gives one local tick, and d=255 keeps the output high for the whole period.
- R7: A duty written while running takes effect only at the next counter wrap from 255 to 0. A duty written while stopped is used from the first period after the run bit is set.
- R8: The cycle after the run bit is written to 1, the counter is at 0 and every output is high.
- R9: The interrupt-enable bit is stored and read back, and has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_rd | input | 1 | Read strobe; data is valid after the next edge |
| bus_addr | input | ADDR_W | Byte address; bits 1:0 are ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pwm_out | output | NCH | One PWM output per channel |

## Verification
The hardest case to reach from the ports is a duty update that lands in the middle of a running period, because its effect must appear exactly one wrap later and not at once. The stimulus sweeps channel 0 through all 256 duty values, and channel 1 through the same values in reverse. Each new value is written partway through the previous period while the pins are sampled every cycle, so each period's measured high time must match the value written one period earlier. Two split prescale values with swapped nibbles, 0x12 and 0x21, then confirm the long-period arithmetic and the nibble placement.

// File: rtl/pwmx_pkg.sv
package pwmx_pkg;
  localparam int unsigned CNT_W      = 8;
  localparam int unsigned PSC_W      = 8;
  localparam int unsigned BUS_W      = 32;
  localparam int unsigned CTRL_OFS   = 32'h50;
  localparam int unsigned IRQ_OFS    = 32'h54;
  localparam int unsigned PSC_LO_LSB = 0;
  localparam int unsigned PSC_HI_LSB = 11;
  localparam int unsigned RUN_BIT    = 9;
  localparam int unsigned NIB_W      = PSC_W / 2;

  typedef struct packed {
    logic             run;
    logic [PSC_W-1:0] presc;
  } cfg_t;
endpackage

// File: rtl/pwmx_regs.sv
module pwmx_regs
  import pwmx_pkg::*;
#(
  parameter int unsigned NCH    = 4,
  parameter int unsigned ADDR_W = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bus_wr,
  input  logic                          bus_rd,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic [BUS_W-1:0]              bus_wdata,
  output logic [BUS_W-1:0]              bus_rdata,
  output cfg_t                          cfg,
  output logic [NCH-1:0][CNT_W-1:0]     duty
);
  localparam int unsigned IDX_W = ADDR_W - 2;
  localparam logic [IDX_W-1:0] CTRL_IDX = IDX_W'(CTRL_OFS / 4);
  localparam logic [IDX_W-1:0] IRQ_IDX  = IDX_W'(IRQ_OFS / 4);

  logic [IDX_W-1:0] widx;
  logic [NCH-1:0]   duty_we;
  logic             ctrl_we;
  logic             irq_we;
  cfg_t             cfg_q, cfg_d;
  logic             irq_q, irq_d;
  logic [BUS_W-1:0] rd_d, rd_q;
  logic             bus_unused;

  assign widx       = bus_addr[ADDR_W-1:2];
  assign ctrl_we    = bus_wr && (widx == CTRL_IDX);
  assign irq_we     = bus_wr && (widx == IRQ_IDX);
  assign bus_unused = ^{bus_wdata[BUS_W-1:PSC_HI_LSB+NIB_W], bus_wdata[10],
                        bus_wdata[8], bus_addr[1:0]};

  // per-channel duty storage, one slot per configured channel
  for (genvar g = 0; g < NCH; g++) begin : g_duty
    logic [CNT_W-1:0] duty_q;
    assign duty_we[g] = bus_wr && (widx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        duty_q <= '0;
      end else if (duty_we[g]) begin
        duty_q <= bus_wdata[CNT_W-1:0];
      end
    end
    assign duty[g] = duty_q;
  end

  always_comb begin
    cfg_d = cfg_q;
    if (ctrl_we) begin
      cfg_d.presc = {bus_wdata[PSC_HI_LSB +: NIB_W], bus_wdata[PSC_LO_LSB +: NIB_W]};
      cfg_d.run   = bus_wdata[RUN_BIT];
    end
  end

  always_comb begin
    irq_d = irq_q;
    if (irq_we) begin
      irq_d = bus_wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      irq_q <= 1'b0;
    end else begin
      cfg_q <= cfg_d;
      irq_q <= irq_d;
    end
  end

  always_comb begin
    rd_d = '0;
    for (int i = 0; i < NCH; i++) begin
      if (widx == IDX_W'(i)) begin
        rd_d[CNT_W-1:0] = duty[i];
      end
    end
    if (widx == CTRL_IDX) begin
      rd_d[PSC_LO_LSB +: NIB_W] = cfg_q.presc[NIB_W-1:0];
      rd_d[PSC_HI_LSB +: NIB_W] = cfg_q.presc[PSC_W-1:NIB_W];
      rd_d[RUN_BIT]             = cfg_q.run;
    end
    if (widx == IRQ_IDX) begin
      rd_d[0] = irq_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else if (bus_rd) begin
      rd_q <= rd_d;
    end
  end

  assign bus_rdata = rd_q;
  assign cfg       = cfg_q;

  // a control write must land in the stored configuration on the next edge
  assert_ctrl_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |=> (cfg_q.run == $past(bus_wdata[RUN_BIT])));
endmodule

// File: rtl/pwmx_timebase.sv
module pwmx_timebase
  import pwmx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  cfg_t             cfg,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  logic [PSC_W-1:0] pdiv_q, pdiv_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             tick;

  assign tick = (pdiv_q >= cfg.presc);

  always_comb begin
    pdiv_d = pdiv_q;
    cnt_d  = cnt_q;
    if (!cfg.run) begin
      pdiv_d = '0;
      cnt_d  = '0;
    end else if (tick) begin
      pdiv_d = '0;
      cnt_d  = cnt_q + 1'b1;
    end else begin
      pdiv_d = pdiv_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pdiv_q <= '0;
      cnt_q  <= '0;
    end else begin
      pdiv_q <= pdiv_d;
      cnt_q  <= cnt_d;
    end
  end

  assign cnt  = cnt_q;
  assign wrap = cfg.run && tick && (cnt_q == '1);

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.run |=> (cnt_q == '0 && pdiv_q == '0));

  assert_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.run && tick) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

  assert_dwell_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.run && !tick) |=> $stable(cnt_q));
endmodule

// File: rtl/pwmx_chan.sv
module pwmx_chan
  import pwmx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             wrap,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] duty_sh,
  output logic             pwm
);
  logic [CNT_W-1:0] act_q;
  logic             load;

  // shadow transfer: continuous while stopped, only at wrap while running
  assign load = !run || wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
    end else if (load) begin
      act_q <= duty_sh;
    end
  end

  assign pwm = run && (cnt <= act_q);

  assert_shadow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wrap) |=> $stable(act_q));
endmodule

// File: rtl/pwmx_core.sv
module pwmx_core
  import pwmx_pkg::*;
#(
  parameter int unsigned NCH    = 4,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [NCH-1:0]    pwm_out
);
  logic [1:0]                   rst_sync_q;
  logic                         rst_s_n;
  cfg_t                         cfg;
  logic [NCH-1:0][CNT_W-1:0]    duty;
  logic [CNT_W-1:0]             cnt;
  logic                         wrap;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_s_n = rst_sync_q[1];

  pwmx_regs #(.NCH(NCH), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cfg       (cfg),
    .duty      (duty)
  );

  pwmx_timebase u_tb (
    .clk   (clk),
    .rst_n (rst_s_n),
    .cfg   (cfg),
    .cnt   (cnt),
    .wrap  (wrap)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    pwmx_chan u_ch (
      .clk     (clk),
      .rst_n   (rst_s_n),
      .run     (cfg.run),
      .wrap    (wrap),
      .cnt     (cnt),
      .duty_sh (duty[g]),
      .pwm     (pwm_out[g])
    );
  end

  assert_quiet_R4: assert property (@(posedge clk) disable iff (!rst_s_n)
    !cfg.run |-> (pwm_out == '0));
endmodule

// File: tb/test_pwmx_core.sv
module test_pwmx_core;
  localparam int NCH = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr, bus_rd;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [3:0]  pwm_out;
  int          n_chk = 0;
  int          n_bad = 0;
  logic        done = 1'b0;

  always #2 clk = ~clk;

  pwmx_core #(.NCH(NCH), .ADDR_W(8)) i_pwmx_core (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pwm_out(pwm_out)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  function automatic logic [31:0] ctrl_word(input int p, input logic run);
    return (32'((p >> 4) & 15) << 11) | (32'(run) << 9) | 32'(p & 15);
  endfunction

  // caller is at the negedge that starts a period; measures nwin periods
  task automatic run_windows(input int p, input int nwin, input int dv[4], input string tag);
    int len;
    int hi[4];
    len = 256 * (p + 1);
    for (int w = 0; w < nwin; w++) begin
      for (int c = 0; c < 4; c++) hi[c] = 0;
      for (int i = 0; i < len; i++) begin
        for (int c = 0; c < 4; c++) begin
          if (pwm_out[c]) hi[c]++;
          if (i == 0) chk({tag, " R5 period start high"}, pwm_out[c], 1);
          if (i == len - 1 && dv[c] < 255) chk({tag, " R5 period end low"}, pwm_out[c], 0);
        end
        @(negedge clk);
      end
      for (int c = 0; c < 4; c++)
        chk({tag, " R6 high time"}, hi[c], (dv[c] + 1) * (p + 1));
    end
  endtask

  initial begin
    logic [31:0] r;
    int hi[4];
    int dv[4];
    bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    chk("R1 outputs", pwm_out, 0);
    rd(8'h00, r); chk("R1 duty0", r, 0);
    rd(8'h0C, r); chk("R1 duty3", r, 0);
    rd(8'h50, r); chk("R1 ctrl", r, 0);
    rd(8'h54, r); chk("R1 irq", r, 0);

    // R2 register map and masking
    wr(8'h04, 32'hABCD12); rd(8'h04, r); chk("R2 duty1 mask", r, 32'h12);
    wr(8'h0B, 32'h77);     rd(8'h08, r); chk("R2 addr low bits ignored", r, 32'h77);
    wr(8'h50, 32'hFFFF_FFFF); wr(8'h50, 32'h0);
    rd(8'h50, r); chk("R2 ctrl cleared", r, 0);
    wr(8'h50, ctrl_word(8'h5A, 1'b0)); rd(8'h50, r); chk("R2 ctrl fields", r, 32'h2800 | 32'hA);
    wr(8'h50, 32'hFFFF_FFFF); rd(8'h50, r); chk("R2 ctrl all ones", r, 32'h7A0F);
    wr(8'h50, 32'h0);
    wr(8'h54, 32'hFFFF_FFFF); rd(8'h54, r); chk("R9 irq stored", r, 1);

    // R3 slots beyond channel count and unmapped offsets
    wr(8'h00, 32'h3C);
    wr(8'h10, 32'hFF); rd(8'h10, r); chk("R3 slot4 reads 0", r, 0);
    wr(8'h4C, 32'hFF); rd(8'h4C, r); chk("R3 slot19 reads 0", r, 0);
    wr(8'h58, 32'hFF); rd(8'h58, r); chk("R3 unmapped reads 0", r, 0);
    rd(8'h00, r); chk("R3 duty0 untouched", r, 32'h3C);
    rd(8'h50, r); chk("R3 ctrl untouched", r, 0);
    chk("R3 outputs untouched", pwm_out, 0);

    // R4 stopped: set duties, outputs stay low
    wr(8'h00, 0); wr(8'h04, 255); wr(8'h08, 128); wr(8'h0C, 7);
    for (int i = 0; i < 300; i++) begin
      if (pwm_out != 0) chk("R4 low while stopped", pwm_out, 0);
      @(negedge clk);
    end
    chk("R4 low while stopped", pwm_out, 0);

    // sweep with p=0; duty updates written mid-period
    wr(8'h50, ctrl_word(0, 1'b1));
    for (int c = 0; c < 4; c++) chk("R8 high right after run", pwm_out[c], 1);
    for (int k = 0; k < 256; k++) begin
      for (int c = 0; c < 4; c++) hi[c] = 0;
      for (int i = 0; i < 256; i++) begin
        for (int c = 0; c < 4; c++) if (pwm_out[c]) hi[c]++;
        if (i == 10) begin
          bus_wr = 1'b1; bus_addr = 8'h00; bus_wdata = 32'((k + 1) & 255);
        end else if (i == 20) begin
          bus_wr = 1'b1; bus_addr = 8'h04; bus_wdata = 32'((254 - k) & 255);
        end else if (i == 30) begin
          bus_wr = 1'b1; bus_addr = 8'h54; bus_wdata = 32'(k & 1);
        end else begin
          bus_wr = 1'b0;
        end
        @(negedge clk);
      end
      chk("R6 R7 ch0 duty from previous period", hi[0], k + 1);
      chk("R6 R7 ch1 duty from previous period", hi[1], 256 - k);
      chk("R9 ch2 unaffected by irq bit", hi[2], 129);
      chk("R9 ch3 unaffected by irq bit", hi[3], 8);
    end

    // R4 stop mid-run
    wr(8'h50, ctrl_word(0, 1'b0));
    chk("R4 low after stop", pwm_out, 0);
    for (int i = 0; i < 50; i++) begin
      if (pwm_out != 0) chk("R4 low after stop", pwm_out, 0);
      @(negedge clk);
    end

    // prescale 0x12, duties written while stopped (R7)
    wr(8'h00, 9); wr(8'h04, 255); wr(8'h08, 0); wr(8'h0C, 200);
    dv = '{9, 255, 0, 200};
    wr(8'h50, ctrl_word(8'h12, 1'b1));
    run_windows(8'h12, 2, dv, "R7 p=0x12");

    wr(8'h50, 0);
    wr(8'h00, 100); wr(8'h04, 1); wr(8'h08, 254); wr(8'h0C, 255);
    dv = '{100, 1, 254, 255};
    wr(8'h50, ctrl_word(8'h21, 1'b1));
    run_windows(8'h21, 1, dv, "p=0x21");
    wr(8'h50, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule